// File: doc/BRIEF.md
# Indexed Read-Modify-Write Bus Sequencer

This block drives the memory bus of an 8-bit processor with a 16-bit address while it executes an indexed store or an indexed read-modify-write instruction. It fetches the operand bytes and forms the effective address. It issues the dummy read that the processor always makes at the address before the page fix-up, and then performs the write or writes. Two addressing forms are handled. In the absolute-indexed form, a 16-bit base is fetched from the instruction stream. In the zero-page indirect post-indexed form, a one-byte pointer is fetched, and the base is then read from zero page through that pointer.

Decode and arithmetic sit outside the block. A controller pulses `start` with the form, the read-modify-write flag, the index register and the program counter. It supplies the store value, or for a read-modify-write it supplies the modified value computed from `read_value`. Each bus access takes one clock. The address and write controls are combinational from the sequencer state. Read data is taken at the clock edge that ends the access.

Top module: `rmw_seq`

## Requirements
- R1: In absolute-indexed form (`mode`=0), the first two accesses read the base low byte at `pc_start` and the base high byte at `pc_start`+1. In indirect form (`mode`=1), the first access reads the pointer at `pc_start`. `pc_out` advances by one for each operand byte, ending at `pc_start`+2 or `pc_start`+1.
- R2: After the base is known, one read is always issued at {base high, (base low + index) mod 256}, whether or not the sum crosses a page.
- R3: The access after that dummy read uses the same low byte, and the high byte is incremented (mod 256) exactly when base low + index exceeded 255.
- R4: In indirect form, the base low byte is read from address 0x00pp and the base high byte from 0x00qq, where pp is the pointer and qq = (pp+1) mod 256, so pointer 0xFF wraps to 0x0000.
- R5: A store (`rmw`=0) writes `store_data` once at the corrected address in the cycle right after the dummy read, and then ends.
- R6: A read-modify-write (`rmw`=1) reads at the corrected address after the dummy read. The value read appears on `read_value` from the next cycle on.
- R7: A read-modify-write then writes the unmodified value to the corrected address, and in the next cycle writes `mod_data` to the same address.
- R8: `cycle_count` clears on an accepted start and rises by one per bus access, dummy accesses included. At `done` it equals 4 (absolute store), 6 (absolute read-modify-write), 5 (indirect store) or 7 (indirect read-modify-write).
- R9: `done` is high for exactly one cycle, the cycle after the final write, with `busy` low. `start` is ignored while `busy` is high.
- R10: Reset leaves the block idle: `we`, `busy` and `done` low, and `cycle_count` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a sequence; sampled only when idle |
| mode | input | 1 | 0 = absolute indexed, 1 = zero-page indirect post-indexed |
| rmw | input | 1 | 1 = read-modify-write, 0 = store |
| index | input | 8 | Index register value, latched at start |
| pc_start | input | 16 | Address of the first operand byte |
| store_data | input | 8 | Value written by a store |
| mod_data | input | 8 | Modified value for the second read-modify-write write |
| rdata | input | 8 | Read data bus |
| addr | output | 16 | Address bus |
| we | output | 1 | Write enable |
| wdata | output | 8 | Write data bus |
| pc_out | output | 16 | Program counter after the operand fetches |
| read_value | output | 8 | Value read at the effective address |
| cycle_count | output | CNT_W | Bus accesses since the last accepted start |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion strobe |

## Verification
The assertions assume that `rdata` is valid at the edge that ends each read. They also assume that `store_data` and `mod_data` are steady during the write cycles that use them. They take no position on what memory returns, so the page fix-up and wrap checks hold for any operand bytes. The bench models memory as a pure function of the address, with operand and pointer bytes placed at chosen locations. It holds the write data constant for each sequence and changes stimulus only on falling edges.

// File: rtl/rmw_seq_pkg.sv
package rmw_seq_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2 * BYTE_W;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_OPLO,
    ST_OPHI,
    ST_PTR,
    ST_INDLO,
    ST_INDHI,
    ST_DUMMY,
    ST_READ,
    ST_WSTORE,
    ST_WBACK,
    ST_WMOD
  } seq_state_t;

  // low byte plus index, carry in the top bit
  function automatic logic [BYTE_W:0] idx_sum(byte_t lo, byte_t idx);
    return {1'b0, lo} + {1'b0, idx};
  endfunction

  // high byte after the page fix-up
  function automatic byte_t page_fix(byte_t hi, logic c);
    return hi + {{(BYTE_W-1){1'b0}}, c};
  endfunction

  // successor of a zero-page pointer, wrapping inside the page
  function automatic byte_t zp_succ(byte_t p);
    return p + byte_t'(1);
  endfunction

  function automatic addr_t join_addr(byte_t hi, byte_t lo);
    return {hi, lo};
  endfunction

  // total bus accesses of one sequence
  function automatic int unsigned access_total(logic ind, logic rw);
    return 32'd4 + (ind ? 32'd1 : 32'd0) + (rw ? 32'd2 : 32'd0);
  endfunction

endpackage

// File: rtl/rmw_seq_fsm.sv
module rmw_seq_fsm
  import rmw_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       mode,
  input  logic       rmw,
  output seq_state_t state,
  output logic       mode_q,
  output logic       rmw_q,
  output logic       accept,
  output logic       access,
  output logic       pc_fetch,
  output logic       dummy_cyc,
  output logic       wr_back,
  output logic       write_cyc,
  output logic       busy,
  output logic       done
);

  seq_state_t nxt;

  assign busy      = (state != ST_IDLE);
  assign accept    = start && !busy;
  assign access    = busy;
  assign pc_fetch  = (state == ST_OPLO) || (state == ST_OPHI) || (state == ST_PTR);
  assign dummy_cyc = (state == ST_DUMMY);
  assign wr_back   = (state == ST_WBACK);
  assign write_cyc = (state == ST_WSTORE) || (state == ST_WBACK) || (state == ST_WMOD);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (start) nxt = mode ? ST_PTR : ST_OPLO;
      ST_OPLO:   nxt = ST_OPHI;
      ST_OPHI:   nxt = ST_DUMMY;
      ST_PTR:    nxt = ST_INDLO;
      ST_INDLO:  nxt = ST_INDHI;
      ST_INDHI:  nxt = ST_DUMMY;
      ST_DUMMY:  nxt = rmw_q ? ST_READ : ST_WSTORE;
      ST_READ:   nxt = ST_WBACK;
      ST_WBACK:  nxt = ST_WMOD;
      ST_WMOD:   nxt = ST_IDLE;
      ST_WSTORE: nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      mode_q <= 1'b0;
      rmw_q  <= 1'b0;
      done   <= 1'b0;
    end else begin
      state <= nxt;
      done  <= (state == ST_WSTORE) || (state == ST_WMOD);
      if (accept) begin
        mode_q <= mode;
        rmw_q  <= rmw;
      end
    end
  end

  // R9: completion strobe lasts one cycle
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: a running sequence keeps its captured form when start toggles
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && state != ST_WSTORE && state != ST_WMOD) |=> busy && $stable(mode_q) && $stable(rmw_q));

  // R7: the unmodified write-back is always followed by a write
  assert_second_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_back |=> write_cyc);

endmodule

// File: rtl/rmw_seq_addr.sv
module rmw_seq_addr
  import rmw_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  seq_state_t state,
  input  addr_t      pc_start,
  input  byte_t      index,
  input  byte_t      rdata,
  input  byte_t      store_data,
  input  byte_t      mod_data,
  output addr_t      addr,
  output byte_t      wdata,
  output addr_t      pc_q,
  output byte_t      rd_q,
  output logic       carry
);

  byte_t ptr_q;
  byte_t base_lo;
  byte_t base_hi;
  byte_t idx_q;
  logic [BYTE_W:0] sum;
  addr_t raw_addr;
  addr_t eff_addr;

  assign sum      = idx_sum(base_lo, idx_q);
  assign carry    = sum[BYTE_W];
  assign raw_addr = join_addr(base_hi, sum[BYTE_W-1:0]);
  assign eff_addr = join_addr(page_fix(base_hi, carry), sum[BYTE_W-1:0]);

  always_comb begin
    addr = pc_q;
    unique case (state)
      ST_INDLO:  addr = join_addr('0, ptr_q);
      ST_INDHI:  addr = join_addr('0, zp_succ(ptr_q));
      ST_DUMMY:  addr = raw_addr;
      ST_READ, ST_WSTORE, ST_WBACK, ST_WMOD: addr = eff_addr;
      default:   addr = pc_q;
    endcase
  end

  always_comb begin
    unique case (state)
      ST_WSTORE: wdata = store_data;
      ST_WBACK:  wdata = rd_q;
      ST_WMOD:   wdata = mod_data;
      default:   wdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      ptr_q   <= '0;
      base_lo <= '0;
      base_hi <= '0;
      idx_q   <= '0;
      rd_q    <= '0;
    end else begin
      if (accept) begin
        pc_q  <= pc_start;
        idx_q <= index;
      end
      unique case (state)
        ST_OPLO:  begin base_lo <= rdata; pc_q <= pc_q + addr_t'(1); end
        ST_OPHI:  begin base_hi <= rdata; pc_q <= pc_q + addr_t'(1); end
        ST_PTR:   begin ptr_q   <= rdata; pc_q <= pc_q + addr_t'(1); end
        ST_INDLO: base_lo <= rdata;
        ST_INDHI: base_hi <= rdata;
        ST_READ:  rd_q    <= rdata;
        default:  ;
      endcase
    end
  end

  // R4: pointer high fetch is the next zero-page byte, wrapping
  assert_zp_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_INDHI) |-> addr[ADDR_W-1:BYTE_W] == '0 &&
      addr[BYTE_W-1:0] == byte_t'($past(addr[BYTE_W-1:0]) + byte_t'(1)));

  // R6: value read at the effective address is what gets written back
  assert_wback_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WBACK) |-> wdata == $past(rdata));

endmodule

// File: rtl/rmw_seq_count.sv
module rmw_seq_count #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (step)  count <= count + CNT_W'(1);
  end

  // R8: every access adds exactly one
  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> count == $past(count) + CNT_W'(1));

endmodule

// File: rtl/rmw_seq.sv
module rmw_seq
  import rmw_seq_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode,
  input  logic              rmw,
  input  logic [7:0]        index,
  input  logic [15:0]       pc_start,
  input  logic [7:0]        store_data,
  input  logic [7:0]        mod_data,
  input  logic [7:0]        rdata,
  output logic [15:0]       addr,
  output logic              we,
  output logic [7:0]        wdata,
  output logic [15:0]       pc_out,
  output logic [7:0]        read_value,
  output logic [CNT_W-1:0]  cycle_count,
  output logic              busy,
  output logic              done
);

  seq_state_t state;
  logic mode_q, rmw_q, accept, access, pc_fetch, dummy_cyc, wr_back, write_cyc;
  logic carry;

  rmw_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode      (mode),
    .rmw       (rmw),
    .state     (state),
    .mode_q    (mode_q),
    .rmw_q     (rmw_q),
    .accept    (accept),
    .access    (access),
    .pc_fetch  (pc_fetch),
    .dummy_cyc (dummy_cyc),
    .wr_back   (wr_back),
    .write_cyc (write_cyc),
    .busy      (busy),
    .done      (done)
  );

  rmw_seq_addr u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .state      (state),
    .pc_start   (pc_start),
    .index      (index),
    .rdata      (rdata),
    .store_data (store_data),
    .mod_data   (mod_data),
    .addr       (addr),
    .wdata      (wdata),
    .pc_q       (pc_out),
    .rd_q       (read_value),
    .carry      (carry)
  );

  rmw_seq_count #(.CNT_W(CNT_W)) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (accept),
    .step  (access),
    .count (cycle_count)
  );

  assign we = write_cyc;

  // R1: every operand fetch advances the program counter by one
  assert_pc_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pc_fetch |=> pc_out == $past(pc_out) + 16'd1);

  // R3: access after the dummy read keeps the low byte and fixes the page
  assert_page_fix_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dummy_cyc |=> addr[7:0] == $past(addr[7:0]) &&
      addr[15:8] == $past(addr[15:8]) + {7'd0, $past(carry)});

  // R2: the first write of a sequence is preceded by a read at the same low byte
  assert_read_before_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we) |-> !$past(we) && $past(addr[7:0]) == addr[7:0]);

  // R7: second write hits the same address as the write-back
  assert_same_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_back |=> we && $stable(addr));

  // R8: access total at completion
  assert_total_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cycle_count == CNT_W'(access_total(mode_q, rmw_q)));

  // R9: completion follows a write and leaves the block idle
  assert_done_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(we));

  // R10: no write outside a sequence
  assert_idle_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !we);

endmodule

// File: tb/test_rmw_seq.sv
`timescale 1ns/1ps
module test_rmw_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mode = 1'b0;
  logic        rmw = 1'b0;
  logic [7:0]  index = '0;
  logic [15:0] pc_start = '0;
  logic [7:0]  store_data = '0;
  logic [7:0]  mod_data = '0;
  logic [7:0]  rdata;
  logic [15:0] addr;
  logic        we;
  logic [7:0]  wdata;
  logic [15:0] pc_out;
  logic [7:0]  read_value;
  logic [3:0]  cycle_count;
  logic        busy;
  logic        done;

  int checks = 0;
  int fails  = 0;

  // memory model stimulus
  logic        m_ind = 1'b0;
  logic [15:0] m_pc = 16'hC0FF;
  logic [7:0]  m_lo = '0, m_hi = '0, m_ptr = '0;

  always #2.5 clk = ~clk;

  rmw_seq i_rmw_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .rmw(rmw),
    .index(index), .pc_start(pc_start), .store_data(store_data),
    .mod_data(mod_data), .rdata(rdata), .addr(addr), .we(we), .wdata(wdata),
    .pc_out(pc_out), .read_value(read_value), .cycle_count(cycle_count),
    .busy(busy), .done(done)
  );

  function automatic logic [7:0] memf(input logic [15:0] a, input logic ind,
      input logic [15:0] p0, input logic [7:0] lo, input logic [7:0] hi,
      input logic [7:0] pt);
    if (!ind && a == p0) return lo;
    if (!ind && a == p0 + 16'd1) return hi;
    if (ind && a == p0) return pt;
    if (ind && a == {8'h00, pt}) return lo;
    if (ind && a == {8'h00, 8'(pt + 8'd1)}) return hi;
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h96;
  endfunction

  assign rdata = memf(addr, m_ind, m_pc, m_lo, m_hi, m_ptr);

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // expected access list
  logic [15:0] ea[8];
  logic        ew[8];
  logic [7:0]  ed[8];
  string       et[8];

  task automatic run(input logic md, input logic rw, input logic [7:0] ix,
      input logic [7:0] lo, input logic [7:0] hi, input logic [7:0] pt,
      input logic [15:0] p0, input logic hold_start);
    int n = 0;
    int effi;
    logic [15:0] eff;
    logic [7:0] sv = lo ^ 8'h3C;
    logic [7:0] mv = hi ^ ix ^ 8'hC3;
    m_ind = md; m_pc = p0; m_lo = lo; m_hi = hi; m_ptr = pt;
    if (!md) begin
      ea[n] = p0;              ew[n] = 0; ed[n] = 0; et[n] = "R1"; n++;
      ea[n] = p0 + 16'd1;      ew[n] = 0; ed[n] = 0; et[n] = "R1"; n++;
    end else begin
      ea[n] = p0;              ew[n] = 0; ed[n] = 0; et[n] = "R1"; n++;
      ea[n] = {8'h00, pt};     ew[n] = 0; ed[n] = 0; et[n] = "R4"; n++;
      ea[n] = 16'(int'(pt + 1) % 256); ew[n] = 0; ed[n] = 0; et[n] = "R4"; n++;
    end
    ea[n] = {hi, 8'((int'(lo) + int'(ix)) % 256)}; ew[n] = 0; ed[n] = 0; et[n] = "R2"; n++;
    effi = (int'(hi) * 256 + int'(lo) + int'(ix)) % 65536;
    eff = 16'(effi);
    if (rw) begin
      ea[n] = eff; ew[n] = 0; ed[n] = 0;                               et[n] = "R3"; n++;
      ea[n] = eff; ew[n] = 1; ed[n] = memf(eff, md, p0, lo, hi, pt);   et[n] = "R7"; n++;
      ea[n] = eff; ew[n] = 1; ed[n] = mv;                              et[n] = "R7"; n++;
    end else begin
      ea[n] = eff; ew[n] = 1; ed[n] = sv;                              et[n] = "R5"; n++;
    end
    @(negedge clk);
    mode = md; rmw = rw; index = ix; pc_start = p0; store_data = sv; mod_data = mv;
    start = 1'b1;
    @(negedge clk);
    if (!hold_start) start = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (hold_start) begin
        mode = ~md; rmw = ~rw; index = ~ix; pc_start = ~p0;
      end
      if (k == n - 1) start = 1'b0;
      chk(et[k], $sformatf("addr step %0d", k), int'(addr), int'(ea[k]));
      chk(et[k], $sformatf("we step %0d", k), int'(we), int'(ew[k]));
      if (ew[k]) chk(et[k], $sformatf("wdata step %0d", k), int'(wdata), int'(ed[k]));
      chk("R9", "busy during sequence", int'(busy), 1);
      @(negedge clk);
    end
    chk("R9", "done strobe", int'(done), 1);
    chk("R9", "busy at done", int'(busy), 0);
    chk("R9", "we at done", int'(we), 0);
    chk("R8", "access count", int'(cycle_count), n);
    chk("R1", "pc advance", int'(pc_out), int'(p0 + (md ? 16'd1 : 16'd2)));
    if (rw) chk("R6", "read value", int'(read_value), int'(memf(eff, md, p0, lo, hi, pt)));
    @(negedge clk);
    chk("R9", "done single cycle", int'(done), 0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog: actual no finish expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0]  idxs[5] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF};
    logic [7:0]  los[4]  = '{8'h00, 8'h01, 8'h80, 8'hFF};
    logic [7:0]  his[2]  = '{8'h12, 8'hFF};
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "we after reset", int'(we), 0);
    chk("R10", "busy after reset", int'(busy), 0);
    chk("R10", "done after reset", int'(done), 0);
    chk("R10", "count after reset", int'(cycle_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "idle after release", int'(busy), 0);
    for (int m = 0; m < 2; m++)
      for (int r = 0; r < 2; r++)
        for (int i = 0; i < 5; i++)
          for (int l = 0; l < 4; l++)
            for (int h = 0; h < 2; h++)
              run(m[0], r[0], idxs[i], los[l], his[h],
                  (l[0] ? 8'hFF : 8'h40),
                  (h[0] ? 16'hC0FF : 16'h5A10),
                  (i == 3));
    // R4 pointer wrap with a distinctive pointer
    run(1'b1, 1'b1, 8'h10, 8'hF8, 8'h33, 8'hFF, 16'h7000, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule